// File: doc/BRIEF.md
# Addressable Bit Latch with Demultiplexer Mode

This block holds a small bank of single-bit storage cells that are written one at a time. A binary address picks one cell, and a serial data bit is loaded into it; every stored bit is driven onto a parallel output bus at all times. Two level controls choose what happens on each rising clock edge: a write-inhibit input and a functional clear input. Together they select one of four modes: addressed write, hold, clear everything, or one-hot demultiplexing of the data bit onto the addressed output.

All inputs are sampled on the rising edge of `clk`, and the output bus is registered. While a cell stays addressed with writes enabled, it takes a new copy of `din` on every edge. A separate synchronous system reset defines the power-up state. A bank-enable input (kept when `USE_BANK_EN` is 1) blocks writes in the same way as the write-inhibit input. This lets two or more instances share a data line and form a wider decoder: an extra address bit drives one instance's bank enable directly and the other's through an inverter. The interface has no data stream, so no valid/ready handshake applies and there is no back-pressure. Every pin is a plain level signal.

Top module: `addr_latch`

## Requirements
- R1: With `wr_dis`=0, `clr`=0 and the bank enabled, the cell at index `addr` (bit 0 of `addr` is the least significant) takes `din` on the edge, and every other cell keeps its value. Example: from all zeros, writing 1 at address 5 gives `q`=8'h20.
- R2: With `wr_dis`=1 and `clr`=0, no cell changes, whatever `addr` and `din` are.
- R3: With `wr_dis`=1 and `clr`=1, every cell is zero after the edge.
- R4: With `wr_dis`=0, `clr`=1 and the bank enabled, the addressed cell takes `din` and every other cell is zero after the edge, so at most one bit of `q` is 1.
- R5: Mode effects appear on `q` one clock after the inputs are sampled. A cell that stays addressed in write mode follows a changing `din` once per clock.
- R6: When `addr` changes while writes are enabled, the previously addressed cell keeps the last value written to it in write mode, or becomes zero in demultiplexer mode. No other cell is disturbed.
- R7: `rst`=1 (synchronous, active high) makes every cell zero after the edge. It overrides all other inputs, and it acts separately from `clr`.
- R8: When `USE_BANK_EN`=1 and `bank_en`=0, the block acts as if `wr_dis`=1: it holds when `clr`=0 and clears when `clr`=1.
- R9: `q` always shows the stored cells. In hold mode, changes to `addr`, `din` and `bank_en` leave `q` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs sampled on its rising edge |
| rst | input | 1 | Synchronous active-high system reset |
| wr_dis | input | 1 | Write inhibit; 1 blocks loading of `din` |
| clr | input | 1 | Functional clear / demultiplexer select |
| bank_en | input | 1 | Cascade enable; 0 blocks writes when `USE_BANK_EN`=1 |
| addr | input | ADDR_W | Cell index, bit 0 least significant |
| din | input | 1 | Serial data bit |
| q | output | NUM_BITS | Parallel view of all stored cells |

## Verification
On every cycle the assertions check the mode rules that one sampled edge fully decides. These are: hold keeps `q` unchanged, clear gives zero, demultiplexer mode leaves at most one bit set with that bit equal to the sampled `din`, the addressed cell takes `din` in write mode, and the system reset clears all cells. The bench scenarios are needed for behaviour that spans several edges or depends on history. That covers which cells survive a sequence of addresses, a previously addressed cell keeping its value after the address moves, a cell tracking `din` cycle by cycle, and the bank enable making one instance of a cascaded pair inert. A reference model of all cells is compared after every edge over long mixed sequences.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;

  // Mode encoding is {write inhibit (effective), functional clear}
  typedef enum logic [1:0] {
    MODE_WRITE = 2'b00,
    MODE_DEMUX = 2'b01,
    MODE_HOLD  = 2'b10,
    MODE_CLEAR = 2'b11
  } latch_mode_e;

endpackage

// File: rtl/addr_latch_mode.sv
module addr_latch_mode #(
  parameter bit USE_BANK_EN = 1'b1
) (
  input  logic wr_dis,
  input  logic clr,
  input  logic bank_en,
  output logic load,
  output logic zero_unsel,
  output logic clear_all
);
  import addr_latch_pkg::*;

  localparam logic BANK_MASK = USE_BANK_EN ? 1'b1 : 1'b0;

  logic        blocked;
  latch_mode_e mode;

  // A disabled bank behaves exactly like an inhibited write
  assign blocked = wr_dis | (BANK_MASK & ~bank_en);
  assign mode    = latch_mode_e'({blocked, clr});

  always_comb begin
    load       = 1'b0;
    zero_unsel = 1'b0;
    clear_all  = 1'b0;
    unique case (mode)
      MODE_WRITE: load = 1'b1;
      MODE_DEMUX: begin
        load       = 1'b1;
        zero_unsel = 1'b1;
      end
      MODE_HOLD:  ;
      MODE_CLEAR: clear_all = 1'b1;
      default:    ;
    endcase
  end

endmodule

// File: rtl/addr_latch_decode.sv
module addr_latch_decode #(
  parameter int NUM_BITS = 8,
  parameter int ADDR_W   = (NUM_BITS > 1) ? $clog2(NUM_BITS) : 1
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_BITS-1:0] sel
);

  // One comparator per cell; an out-of-range index selects nothing
  for (genvar i = 0; i < NUM_BITS; i++) begin : g_cmp
    assign sel[i] = (addr == ADDR_W'(i));
  end

endmodule

// File: rtl/addr_latch_cell.sv
module addr_latch_cell (
  input  logic clk,
  input  logic rst,
  input  logic sel,
  input  logic din,
  input  logic load,
  input  logic zero_unsel,
  input  logic clear_all,
  output logic bit_q
);

  logic bit_d;

  always_comb begin
    if (clear_all)        bit_d = 1'b0;
    else if (load && sel) bit_d = din;
    else if (zero_unsel)  bit_d = 1'b0;
    else                  bit_d = bit_q;
  end

  always_ff @(posedge clk) begin
    if (rst) bit_q <= 1'b0;
    else     bit_q <= bit_d;
  end

endmodule

// File: rtl/addr_latch.sv
module addr_latch #(
  parameter int NUM_BITS    = 8,
  parameter int ADDR_W      = (NUM_BITS > 1) ? $clog2(NUM_BITS) : 1,
  parameter bit USE_BANK_EN = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_dis,
  input  logic                clr,
  input  logic                bank_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                din,
  output logic [NUM_BITS-1:0] q
);

  logic [NUM_BITS-1:0] sel;
  logic                load;
  logic                zero_unsel;
  logic                clear_all;

  addr_latch_mode #(
    .USE_BANK_EN (USE_BANK_EN)
  ) u_mode (
    .wr_dis     (wr_dis),
    .clr        (clr),
    .bank_en    (bank_en),
    .load       (load),
    .zero_unsel (zero_unsel),
    .clear_all  (clear_all)
  );

  addr_latch_decode #(
    .NUM_BITS (NUM_BITS),
    .ADDR_W   (ADDR_W)
  ) u_dec (
    .addr (addr),
    .sel  (sel)
  );

  for (genvar i = 0; i < NUM_BITS; i++) begin : g_cell
    addr_latch_cell u_cell (
      .clk        (clk),
      .rst        (rst),
      .sel        (sel[i]),
      .din        (din),
      .load       (load),
      .zero_unsel (zero_unsel),
      .clear_all  (clear_all),
      .bit_q      (q[i])
    );
  end

endmodule

// File: rtl/addr_latch_chk.sv
module addr_latch_chk #(
  parameter int NUM_BITS    = 8,
  parameter int ADDR_W      = 3,
  parameter bit USE_BANK_EN = 1'b1
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_dis,
  input logic                clr,
  input logic                bank_en,
  input logic [ADDR_W-1:0]   addr,
  input logic                din,
  input logic [NUM_BITS-1:0] q
);

  logic open_bank;
  assign open_bank = USE_BANK_EN ? bank_en : 1'b1;

  // R2
  hold_keeps_q_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_dis && !clr) |=> q == $past(q));

  // R3
  clear_zeroes_q_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_dis && clr) |=> q == '0);

  // R4
  demux_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_dis && clr && open_bank) |=> $onehot0(q));

  // R4
  demux_data_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_dis && clr && open_bank && (int'(addr) < NUM_BITS))
      |=> $countones(q) == int'($past(din)));

  // R1
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_dis && !clr && open_bank && (int'(addr) < NUM_BITS))
      |=> q[$past(addr)] == $past(din));

  // R8
  bank_off_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (USE_BANK_EN && !bank_en && !clr) |=> q == $past(q));

  // R7
  sys_reset_chk: assert property (@(posedge clk)
    rst |=> q == '0);

endmodule

bind addr_latch addr_latch_chk #(
  .NUM_BITS    (NUM_BITS),
  .ADDR_W      (ADDR_W),
  .USE_BANK_EN (USE_BANK_EN)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_dis  (wr_dis),
  .clr     (clr),
  .bank_en (bank_en),
  .addr    (addr),
  .din     (din),
  .q       (q)
);

// File: tb/test_addr_latch.sv
module test_addr_latch;

  localparam int NB = 8;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_dis = 1'b1;
  logic          clr = 1'b0;
  logic          bank_en = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          din = 1'b0;
  logic [NB-1:0] q;

  logic [NB-1:0] model = '0;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  addr_latch #(.NUM_BITS(NB), .ADDR_W(AW), .USE_BANK_EN(1'b1)) i_addr_latch (
    .clk(clk), .rst(rst), .wr_dis(wr_dis), .clr(clr), .bank_en(bank_en),
    .addr(addr), .din(din), .q(q)
  );

  task automatic chk(input string tag, input logic [NB-1:0] act, input logic [NB-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: q=%h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Apply one edge's worth of inputs, update the model from the mode rules,
  // and return at the following falling edge where q has settled.
  task automatic step(input logic r, input logic wd, input logic cl, input logic be,
                      input logic [AW-1:0] a, input logic d);
    rst = r; wr_dis = wd; clr = cl; bank_en = be; addr = a; din = d;
    @(posedge clk);
    if (r) model = '0;
    else if (wd || !be) begin
      if (cl) model = '0;
    end else begin
      if (cl) model = '0;
      model[a] = d;
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    step(1, 0, 0, 1, 3'd3, 1);
    chk("R7 reset beats write", q, 8'h00);
    step(0, 0, 0, 1, 3'd6, 1);
    step(1, 1, 0, 1, 3'd0, 0);
    chk("R7 system reset clears", q, 8'h00);
  endtask

  task automatic t_write();
    step(0, 0, 0, 1, 3'd5, 1);
    chk("R1 addr 5 -> bit 5", q, 8'h20);
    step(0, 0, 0, 1, 3'd0, 1);
    chk("R1 addr 0 is LSB", q, 8'h21);
    step(0, 0, 0, 1, 3'd7, 1);
    chk("R1 addr 7", q, 8'hA1);
    step(0, 0, 0, 1, 3'd5, 0);
    chk("R1 write zero", q, 8'h81);
  endtask

  task automatic t_follow();
    step(0, 0, 0, 1, 3'd2, 1);
    chk("R5 follows 1", q, 8'h85);
    step(0, 0, 0, 1, 3'd2, 0);
    chk("R5 follows 0", q, 8'h81);
    step(0, 0, 0, 1, 3'd2, 1);
    chk("R5 follows 1 again", q, 8'h85);
    // Inputs changed mid-cycle are invisible until the next edge
    din = 1'b0;
    #1;
    chk("R5 no change before edge", q, 8'h85);
  endtask

  task automatic t_hold();
    logic [NB-1:0] snap;
    snap = q;
    for (int i = 0; i < NB; i++) begin
      step(0, 1, 0, i[0], AW'(i), ~i[1]);
      chk("R2 hold ignores addr/din", q, snap);
    end
    chk("R9 outputs visible in hold", q, model);
  endtask

  task automatic t_addr_change();
    step(0, 0, 0, 1, 3'd3, 1);
    step(0, 0, 0, 1, 3'd4, 1);
    chk("R6 old bit keeps value", q, 8'h9D);
    step(0, 0, 0, 1, 3'd4, 0);
    chk("R6 only new bit moves", q, 8'h8D);
  endtask

  task automatic t_demux();
    step(0, 0, 1, 1, 3'd6, 1);
    chk("R4 demux one-hot", q, 8'h40);
    step(0, 0, 1, 1, 3'd1, 1);
    chk("R6 demux old bit zero", q, 8'h02);
    step(0, 0, 1, 1, 3'd1, 0);
    chk("R4 demux data zero", q, 8'h00);
  endtask

  task automatic t_clear();
    step(0, 0, 0, 1, 3'd2, 1);
    step(0, 0, 0, 1, 3'd7, 1);
    chk("R1 setup for clear", q, 8'h84);
    step(0, 1, 1, 1, 3'd2, 1);
    chk("R3 clear all", q, 8'h00);
  endtask

  task automatic t_bank();
    step(0, 0, 0, 1, 3'd4, 1);
    step(0, 0, 0, 0, 3'd1, 1);
    chk("R8 bank off holds", q, 8'h10);
    step(0, 0, 1, 0, 3'd1, 1);
    chk("R8 bank off clears", q, 8'h00);
  endtask

  task automatic t_random();
    for (int n = 0; n < 2000; n++) begin
      logic [7:0] r;
      r = 8'($urandom());
      step(r[7:5] == 3'd0 && n[4:0] == 5'd0, r[0], r[1] & r[2], r[3] | r[4], AW'(r[7:5]), r[6] ^ r[5] ^ r[1]);
      chk("R1-mix model compare", q, model);
    end
  endtask

  initial begin
    t_reset();
    t_write();
    t_follow();
    t_hold();
    t_addr_change();
    t_demux();
    t_clear();
    t_bank();
    t_random();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5ns * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, q=%h expected completion", q);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule